// File: doc/BRIEF.md
# Predictive Synchronous Rectifier Gate Timer

This block controls the gate of one synchronous rectifier switch on the secondary side of a resonant converter. Its input is a single bit from a drain-voltage comparator. The bit is high while the switch's body diode conducts, meaning the drain sits below the sensing threshold. The bit is assumed to be synchronised to the block clock upstream. The block debounces the start of conduction and turns the gate on after a fixed number of cycles. It measures how long each conduction interval lasts. In the following interval it predicts when to turn the gate off: the last measured duration minus a programmed dead time, minus a further shrink amount supplied by a separate protection block.

Timing is counted in clock cycles. Default parameters assume a 100 MHz clock: 15 cycles of debounce and 20 cycles of propagation, so the gate turns on 35 cycles after conduction starts. The block has a light-load idle mode. When a debounced conduction interval is shorter than a threshold, the gate is held off. The threshold is 375 cycles in the low-frequency setting and 190 cycles in the high-frequency setting.

Edges are numbered from the start of a conduction interval. Edge 1 is the first rising clock edge that samples `vds_low` high. A conduction of N cycles means edges 1..N sample it high and edge N+1 samples it low. The controller has five states:
- WAIT: idle, waiting for conduction.
- DEBOUNCE: waiting for the debounce count.
- PROPAGATE: waiting for the turn-on instant.
- DRIVE: gate on.
- BLOCKED: gate held off for the rest of the interval.

Its transitions are named as follows:
- start: WAIT to DEBOUNCE, when `vds_low` is sampled high.
- settle: DEBOUNCE to PROPAGATE, at edge DEB_CYC.
- fire: PROPAGATE to DRIVE, at edge DEB_CYC+PROP_CYC when firing is allowed.
- veto: PROPAGATE to BLOCKED, at the same edge when firing is not allowed.
- expire: DRIVE to BLOCKED, when the predicted off edge is reached.
- release: any busy state back to WAIT, whenever `vds_low` is sampled low.

Top module: `sr_gate_timer`

## Requirements
- R1: While reset is applied and immediately after it, `gate` is low and no conduction measurement is stored.
- R2: When firing is allowed, `gate` goes high at edge 35 (DEB_CYC+PROP_CYC) of a conduction interval.
- R3: The first debounced conduction interval after reset never drives the gate, because no earlier measurement exists.
- R4: With a stored duration L, the predicted off edge is P = L − `dead_cyc` − `shrink_cyc`. The gate goes low at edge P, so it is high for P − 35 cycles. If P ≤ 35 the gate stays low for the whole interval.
- R5: If conduction ends before the predicted off edge, `gate` goes low at the first edge that samples `vds_low` low (edge N+1).
- R6: The value of `shrink_cyc` shortens the on-time cycle for cycle. When `dead_cyc` + `shrink_cyc` ≥ L, the prediction clamps to zero and the gate stays low.
- R7: A conduction interval shorter than DEB_CYC (15) cycles neither drives the gate nor replaces the stored duration.
- R8: A debounced duration below the threshold enters idle mode, and idle mode keeps the gate low in every following interval. The threshold is 375 cycles when `hf_mode` = 0 and 190 cycles when `hf_mode` = 1, taken from `hf_mode` at the end of the interval.
- R9: A debounced duration equal to or above the threshold leaves idle mode, and the next interval drives the gate again.
- R10: Durations are held in 12-bit counts that saturate at 4095 instead of wrapping. A conduction longer than 4095 cycles is stored as 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vds_low | input | 1 | Comparator bit, high while the drain is below threshold |
| dead_cyc | input | 12 | Programmed dead time in cycles |
| hf_mode | input | 1 | 1 selects the high-frequency idle threshold |
| shrink_cyc | input | 12 | Extra on-time reduction from the protection block, in cycles |
| gate | output | 1 | Rectifier gate command |

## Verification
Every result is tied to an edge number within the conduction interval:
- turn-on lands on edge 35;
- a predicted turn-off lands on edge P;
- an early end of conduction turns the gate off on edge N+1;
- a new stored duration and idle decision take effect from edge N+1, so they govern the next interval.

The bench raises `vds_low` on a falling clock edge before edge 1 and reads `gate` on the falling edge after every rising edge. It records the edge index of the first high and the first low sample and compares both indices with the values its own reference model predicts. The model holds the stored duration and idle flag and updates them only after each interval.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

    typedef enum logic [2:0] {
        ST_WAIT      = 3'd0,
        ST_DEBOUNCE  = 3'd1,
        ST_PROPAGATE = 3'd2,
        ST_DRIVE     = 3'd3,
        ST_BLOCKED   = 3'd4
    } sr_state_e;

endpackage

// File: rtl/sr_cond_meter.sv
module sr_cond_meter #(
    parameter int CNT_W   = 12,
    parameter int DEB_CYC = 15,
    parameter int THR_LF  = 375,
    parameter int THR_HF  = 190
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vds_low,
    input  logic             hf_mode,
    output logic [CNT_W-1:0] run_cnt,
    output logic [CNT_W-1:0] elapsed,
    output logic [CNT_W-1:0] last_dur,
    output logic             meas_valid,
    output logic             idle_q
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] DEB_C    = CNT_W'(DEB_CYC);
    localparam logic [CNT_W-1:0] THR_LF_C = CNT_W'(THR_LF);
    localparam logic [CNT_W-1:0] THR_HF_C = CNT_W'(THR_HF);

    logic [CNT_W-1:0] thr_sel;

    // Count of cycles including the present sample, saturating
    always_comb begin
        if (!vds_low)
            elapsed = '0;
        else if (run_cnt == CNT_MAX)
            elapsed = CNT_MAX;
        else
            elapsed = run_cnt + 1'b1;
    end

    always_comb thr_sel = hf_mode ? THR_HF_C : THR_LF_C;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt    <= '0;
            last_dur   <= '0;
            meas_valid <= 1'b0;
            idle_q     <= 1'b0;
        end else if (vds_low) begin
            run_cnt <= elapsed;
        end else begin
            run_cnt <= '0;
            if (run_cnt >= DEB_C) begin
                last_dur   <= run_cnt;
                meas_valid <= 1'b1;
                idle_q     <= (run_cnt < thr_sel);
            end
        end
    end

endmodule

// File: rtl/sr_offtime_calc.sv
module sr_offtime_calc #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] last_dur,
    input  logic [CNT_W-1:0] dead_cyc,
    input  logic [CNT_W-1:0] shrink_cyc,
    output logic [CNT_W-1:0] off_at
);

    localparam int EXT_W = CNT_W + 2;

    logic [EXT_W-1:0] diff;

    always_comb begin
        diff = {2'b00, last_dur} - {2'b00, dead_cyc} - {2'b00, shrink_cyc};
        if (diff[EXT_W-1])
            off_at = '0;
        else
            off_at = diff[CNT_W-1:0];
    end

endmodule

// File: rtl/sr_gate_timer.sv
module sr_gate_timer
    import sr_gate_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int DEB_CYC  = 15,
    parameter int PROP_CYC = 20,
    parameter int THR_LF   = 375,
    parameter int THR_HF   = 190
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vds_low,
    input  logic [CNT_W-1:0] dead_cyc,
    input  logic             hf_mode,
    input  logic [CNT_W-1:0] shrink_cyc,
    output logic             gate
);

    localparam logic [CNT_W-1:0] DEB_C  = CNT_W'(DEB_CYC);
    localparam logic [CNT_W-1:0] TON_C  = CNT_W'(DEB_CYC + PROP_CYC);

    sr_state_e        state_q, state_d;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] last_dur;
    logic [CNT_W-1:0] off_at;
    logic             meas_valid;
    logic             idle_q;
    logic             fire_ok;

    sr_cond_meter #(
        .CNT_W  (CNT_W),
        .DEB_CYC(DEB_CYC),
        .THR_LF (THR_LF),
        .THR_HF (THR_HF)
    ) meter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .vds_low   (vds_low),
        .hf_mode   (hf_mode),
        .run_cnt   (run_cnt),
        .elapsed   (elapsed),
        .last_dur  (last_dur),
        .meas_valid(meas_valid),
        .idle_q    (idle_q)
    );

    sr_offtime_calc #(
        .CNT_W(CNT_W)
    ) calc_i (
        .last_dur  (last_dur),
        .dead_cyc  (dead_cyc),
        .shrink_cyc(shrink_cyc),
        .off_at    (off_at)
    );

    always_comb fire_ok = meas_valid && !idle_q && (off_at > elapsed);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_WAIT;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (vds_low)
                    state_d = ST_DEBOUNCE;
            end
            ST_DEBOUNCE: begin
                if (!vds_low)
                    state_d = ST_WAIT;
                else if (elapsed >= DEB_C)
                    state_d = ST_PROPAGATE;
            end
            ST_PROPAGATE: begin
                if (!vds_low)
                    state_d = ST_WAIT;
                else if (elapsed >= TON_C)
                    state_d = fire_ok ? ST_DRIVE : ST_BLOCKED;
            end
            ST_DRIVE: begin
                if (!vds_low)
                    state_d = ST_WAIT;
                else if (elapsed >= off_at)
                    state_d = ST_BLOCKED;
            end
            ST_BLOCKED: begin
                if (!vds_low)
                    state_d = ST_WAIT;
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // Output decode
    always_comb gate = (state_q == ST_DRIVE);

endmodule

// File: rtl/sr_gate_timer_chk.sv
module sr_gate_timer_chk #(
    parameter int CNT_W = 12,
    parameter int T_ON  = 35
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vds_low,
    input logic             gate,
    input logic [CNT_W-1:0] run_cnt,
    input logic [CNT_W-1:0] off_at,
    input logic             meas_valid,
    input logic             idle_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] TON_C   = CNT_W'(T_ON);

    AST_GATE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> $past(vds_low)); // R5

    AST_NO_GATE_UNMEASURED: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |-> !gate); // R3

    AST_IDLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> !$past(idle_q)); // R8

    AST_TURN_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> (run_cnt == TON_C)); // R2

    AST_OFF_BY_PRED: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (run_cnt < off_at)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_cnt) == CNT_MAX && $past(vds_low)) |-> (run_cnt == CNT_MAX)); // R10

endmodule

bind sr_gate_timer sr_gate_timer_chk #(
    .CNT_W(CNT_W),
    .T_ON (DEB_CYC + PROP_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vds_low   (vds_low),
    .gate      (gate),
    .run_cnt   (run_cnt),
    .off_at    (off_at),
    .meas_valid(meas_valid),
    .idle_q    (idle_q)
);

// File: tb/sr_gate_timer_tb_top.sv
`timescale 1ns/1ps
module sr_gate_timer_tb_top;

    localparam int T_ON = 35;
    localparam int DEB  = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vds_low = 1'b0;
    logic        hf_mode = 1'b0;
    logic [11:0] dead_cyc = '0;
    logic [11:0] shrink_cyc = '0;
    logic        gate;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    int m_last = 0;
    bit m_have = 1'b0;
    bit m_idle = 1'b0;

    always #2.5 clk = ~clk;

    sr_gate_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .vds_low   (vds_low),
        .dead_cyc  (dead_cyc),
        .hf_mode   (hf_mode),
        .shrink_cyc(shrink_cyc),
        .gate      (gate)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One conduction interval of n cycles; checks gate rise/fall edges
    task automatic run_pulse(input int n, input string req);
        int rise = 0;
        int fall = 0;
        int p;
        int exp_rise;
        int exp_fall;
        int stray = 0;
        bit on;
        p = m_last - int'(dead_cyc) - int'(shrink_cyc);
        if (p < 0) p = 0;
        on = m_have && !m_idle && (p > T_ON) && (n >= T_ON);
        exp_rise = on ? T_ON : 0;
        exp_fall = on ? ((p < n + 1) ? p : n + 1) : 0;
        @(negedge clk);
        vds_low = 1'b1;
        for (int k = 1; k <= n + 1; k++) begin
            @(negedge clk);
            if (gate && rise == 0) rise = k;
            if (!gate && rise != 0 && fall == 0) fall = k;
            if (k == n) vds_low = 1'b0;
        end
        chk(req, "rise edge", rise, exp_rise);
        chk(req, "fall edge", fall, exp_fall);
        if (n >= DEB) begin
            m_last = (n > 4095) ? 4095 : n;
            m_have = 1'b1;
            m_idle = (m_last < (hf_mode ? 190 : 375));
        end
        for (int g = 0; g < 10; g++) begin
            @(negedge clk);
            if (gate) stray++;
        end
        chk(req, "gate between intervals", stray, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "gate in reset", int'(gate), 0);
        rst_n = 1'b1;
        m_last = 0; m_have = 1'b0; m_idle = 1'b0;
        @(negedge clk);
        chk("R1", "gate after reset", int'(gate), 0);
    endtask

    task automatic t_first_cycle();
        dead_cyc = 12'd10; shrink_cyc = '0; hf_mode = 1'b0;
        run_pulse(500, "R3");
    endtask

    task automatic t_steady();
        run_pulse(500, "R2 R4");
        dead_cyc = 12'd50;
        run_pulse(500, "R4");
        dead_cyc = 12'd470;               // P = 30 <= 35
        run_pulse(500, "R4");
        dead_cyc = 12'd10;
    endtask

    task automatic t_early_end();
        run_pulse(600, "R4");
        run_pulse(300, "R5");             // prev 600: P = 590, ends at 301
    endtask

    task automatic t_shrink();
        run_pulse(500, "R6");             // prev 300 idle check aside
        shrink_cyc = 12'd100;
        run_pulse(500, "R6");             // P = 390
        shrink_cyc = 12'd495;
        run_pulse(500, "R6");             // clamps to zero
        shrink_cyc = '0;
    endtask

    task automatic t_glitch();
        run_pulse(500, "R7");
        run_pulse(10, "R7");              // not recorded
        run_pulse(600, "R7");             // still uses 500: P = 490
    endtask

    task automatic t_idle_lf();
        hf_mode = 1'b0;
        run_pulse(300, "R8");             // enters idle
        run_pulse(375, "R8");             // suppressed, records 375
        run_pulse(400, "R9");             // gate back, P = 365
        run_pulse(374, "R8");
        run_pulse(500, "R8");             // suppressed
    endtask

    task automatic t_idle_hf();
        hf_mode = 1'b1;
        run_pulse(200, "R9");
        run_pulse(300, "R8 R9");          // P = 190
        run_pulse(189, "R8");
        run_pulse(300, "R8");             // suppressed
        run_pulse(190, "R9");
        run_pulse(300, "R9");             // P = 180
        hf_mode = 1'b0;
    endtask

    task automatic t_saturate();
        dead_cyc = '0;
        run_pulse(500, "R10");
        run_pulse(4200, "R10");           // stored as 4095
        run_pulse(5000, "R10");           // off at 4095
        dead_cyc = 12'd10;
    endtask

    initial begin
        #(5.0 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_first_cycle();
        t_steady();
        t_early_end();
        t_shrink();
        t_glitch();
        t_idle_lf();
        t_idle_hf();
        t_saturate();
        t_reset();
        t_first_cycle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule